// File: doc/BRIEF.md
# Protocol Handler Dispatch Unit

This unit starts and stops the protocol-handler thread of a multithreaded core. Coherence messages, each a header plus a line address, arrive on one of two ports. One port carries requests from the local miss path. The other carries traffic from the network. Each port holds one pending message. When the protocol thread is idle, one pending message is chosen. The low bits of its header select a handler entry address from a small jump table. That address is loaded into the protocol program counter, and the run flag is raised so that the fetch stage begins fetching for the protocol context.

The fetch stage drops the run flag by pulsing an end indication once it has fetched the handler's final instruction. While the handler runs, it reads the message it serves through two uncached loads. The blocking header read completes only after a message has been dispatched that has not yet been returned to the thread. The context read always returns the address of the message most recently dispatched. The protocol context is bound to the core permanently, so this unit never saves or restores thread state.

Top module: `proto_dispatch`

## Requirements
- R1: While reset is held, the run flag `ppcv` is 0, both `lmi_ready` and `ni_ready` are 1, and `sw_ack` is 0.
- R2: Each port holds one message. A message is accepted in a cycle where valid and ready are both 1, and ready stays 0 from the next cycle until that message is dispatched.
- R3: Dispatch takes place in the cycle after a message is held, provided `ppcv` is 0. From the next cycle, `ppcv` is 1 and `ppc` equals the jump-table entry selected by header bits [TYPE_W-1:0], which are 4 bits by default.
- R4: While `ppcv` is 1, no message is dispatched. A waiting message stays held, and `ppc` keeps its value.
- R5: A `fetch_last` pulse while `ppcv` is 1 clears `ppcv` in the next cycle. A waiting message can be dispatched no earlier than the cycle after that. A `fetch_last` pulse while `ppcv` is 0 has no effect.
- R6: When both ports hold a message, the port that was not granted most recently wins. The local port wins the first tie after reset.
- R7: `sw_ack` is 1 only while `sw_req` is 1 and a dispatched message has not yet been returned. `sw_data` then carries that message's header, and each dispatched message is returned exactly once.
- R8: `ctx_addr` carries the address of the most recently dispatched message.
- R9: A write with `jt_we` set stores `jt_pc` at entry `jt_idx`. Every later dispatch of that type starts at the new value.
- R10: At most one message is dispatched per cycle. The port that loses a tie keeps its message, and its ready stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lmi_valid | input | 1 | Local miss message present |
| lmi_ready | output | 1 | Local slot empty |
| lmi_hdr | input | HDR_W | Local message header |
| lmi_addr | input | ADDR_W | Local message address |
| ni_valid | input | 1 | Network message present |
| ni_ready | output | 1 | Network slot empty |
| ni_hdr | input | HDR_W | Network message header |
| ni_addr | input | ADDR_W | Network message address |
| jt_we | input | 1 | Jump-table write enable |
| jt_idx | input | TYPE_W | Jump-table write index |
| jt_pc | input | PC_W | Jump-table write data |
| ppc | output | PC_W | Protocol program counter |
| ppcv | output | 1 | Protocol run flag |
| fetch_last | input | 1 | Fetch stage has taken the handler's last instruction |
| sw_req | input | 1 | Blocking header read pending |
| sw_ack | output | 1 | Header read completes this cycle |
| sw_data | output | HDR_W | Header returned to the thread |
| ctx_addr | output | ADDR_W | Address of the current message |

## Verification
Two pairs of functions can act in the same cycle. The first pair is the two ports: the bench loads both slots on the same edge, once after a network grant and once after a local grant. It judges the outcome from the order in which the jump-table entries appear on `ppc`, and from the loser's ready staying low. The second pair is handler end and a waiting dispatch: a network message is parked while a handler runs, then `fetch_last` is pulsed. The bench expects one cycle with `ppcv` low before the parked message's entry address appears, and it checks that the address context changes only at that point.

// File: rtl/hd_pkg.sv
package hd_pkg;
  localparam int NUM_SRC = 2;
  typedef enum logic [0:0] {SRC_LMI = 1'b0, SRC_NI = 1'b1} src_e;
endpackage

// File: rtl/hd_msg_slot.sv
module hd_msg_slot #(
  parameter int HDR_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [HDR_W-1:0]  in_hdr,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              pop,
  output logic              full,
  output logic [HDR_W-1:0]  hdr,
  output logic [ADDR_W-1:0] addr
);
  logic full_nxt;
  logic load;

  assign in_ready = !full;
  assign load     = in_valid && !full;

  always_comb begin
    full_nxt = full;
    if (pop)  full_nxt = 1'b0;
    if (load) full_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full <= 1'b0;
    else        full <= full_nxt;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      hdr  <= in_hdr;
      addr <= in_addr;
    end
  end
endmodule

// File: rtl/hd_rr_arb.sv
module hd_rr_arb #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         adv,
  output logic [N-1:0] grant
);
  localparam int LAST_W = (N > 1) ? $clog2(N) : 1;

  logic [LAST_W-1:0] last_q, last_nxt;

  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(last_q) + k) % N;
      if (!found && req[idx]) begin
        grant[idx] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  always_comb begin
    last_nxt = last_q;
    if (adv) begin
      for (int k = 0; k < N; k++) begin
        if (grant[k]) last_nxt = LAST_W'(k);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= LAST_W'(N - 1);
    else        last_q <= last_nxt;
  end
endmodule

// File: rtl/hd_jump_table.sv
module hd_jump_table #(
  parameter int IDX_W = 4,
  parameter int PC_W  = 32
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [PC_W-1:0]  wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [PC_W-1:0]  rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [PC_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/proto_dispatch.sv
module proto_dispatch
  import hd_pkg::*;
#(
  parameter int TYPE_W = 4,
  parameter int HDR_W  = 16,
  parameter int ADDR_W = 32,
  parameter int PC_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lmi_valid,
  output logic              lmi_ready,
  input  logic [HDR_W-1:0]  lmi_hdr,
  input  logic [ADDR_W-1:0] lmi_addr,
  input  logic              ni_valid,
  output logic              ni_ready,
  input  logic [HDR_W-1:0]  ni_hdr,
  input  logic [ADDR_W-1:0] ni_addr,
  input  logic              jt_we,
  input  logic [TYPE_W-1:0] jt_idx,
  input  logic [PC_W-1:0]   jt_pc,
  output logic [PC_W-1:0]   ppc,
  output logic              ppcv,
  input  logic              fetch_last,
  input  logic              sw_req,
  output logic              sw_ack,
  output logic [HDR_W-1:0]  sw_data,
  output logic [ADDR_W-1:0] ctx_addr
);
  // reset: asserted asynchronously, released after two clean edges
  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  // per-port message slots
  logic [NUM_SRC-1:0] s_valid, s_ready, s_full, s_pop;
  logic [HDR_W-1:0]   s_in_hdr  [NUM_SRC];
  logic [ADDR_W-1:0]  s_in_addr [NUM_SRC];
  logic [HDR_W-1:0]   s_hdr     [NUM_SRC];
  logic [ADDR_W-1:0]  s_addr    [NUM_SRC];

  assign s_valid[SRC_LMI]   = lmi_valid;
  assign s_valid[SRC_NI]    = ni_valid;
  assign s_in_hdr[SRC_LMI]  = lmi_hdr;
  assign s_in_hdr[SRC_NI]   = ni_hdr;
  assign s_in_addr[SRC_LMI] = lmi_addr;
  assign s_in_addr[SRC_NI]  = ni_addr;
  assign lmi_ready          = s_ready[SRC_LMI];
  assign ni_ready           = s_ready[SRC_NI];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
    hd_msg_slot #(.HDR_W(HDR_W), .ADDR_W(ADDR_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_q),
      .in_valid (s_valid[g]),
      .in_ready (s_ready[g]),
      .in_hdr   (s_in_hdr[g]),
      .in_addr  (s_in_addr[g]),
      .pop      (s_pop[g]),
      .full     (s_full[g]),
      .hdr      (s_hdr[g]),
      .addr     (s_addr[g])
    );
  end

  // arbitration, gated by the run flag so handlers never overlap
  logic [NUM_SRC-1:0] arb_req, grant;
  logic               dispatch;

  assign arb_req  = s_full & {NUM_SRC{!ppcv}};
  assign dispatch = |grant;
  assign s_pop    = grant;

  hd_rr_arb #(.N(NUM_SRC)) u_arb (
    .clk   (clk),
    .rst_n (rst_q),
    .req   (arb_req),
    .adv   (dispatch),
    .grant (grant)
  );

  // selected message
  logic [HDR_W-1:0]  sel_hdr;
  logic [ADDR_W-1:0] sel_addr;

  always_comb begin
    sel_hdr  = '0;
    sel_addr = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (grant[k]) begin
        sel_hdr  = sel_hdr  | s_hdr[k];
        sel_addr = sel_addr | s_addr[k];
      end
    end
  end

  logic [PC_W-1:0] start_pc;

  hd_jump_table #(.IDX_W(TYPE_W), .PC_W(PC_W)) u_jt (
    .clk   (clk),
    .we    (jt_we),
    .widx  (jt_idx),
    .wdata (jt_pc),
    .ridx  (sel_hdr[TYPE_W-1:0]),
    .rdata (start_pc)
  );

  // protocol context state
  logic              ppcv_nxt, fresh_q, fresh_nxt;
  logic [HDR_W-1:0]  cur_hdr;
  logic [ADDR_W-1:0] cur_addr;

  assign sw_ack   = sw_req && fresh_q;
  assign sw_data  = cur_hdr;
  assign ctx_addr = cur_addr;

  always_comb begin
    ppcv_nxt = ppcv;
    if (ppcv && fetch_last) ppcv_nxt = 1'b0;
    if (dispatch)           ppcv_nxt = 1'b1;
    fresh_nxt = fresh_q;
    if (sw_ack)   fresh_nxt = 1'b0;
    if (dispatch) fresh_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      ppcv    <= 1'b0;
      fresh_q <= 1'b0;
    end else begin
      ppcv    <= ppcv_nxt;
      fresh_q <= fresh_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      ppc      <= '0;
      cur_hdr  <= '0;
      cur_addr <= '0;
    end else if (dispatch) begin
      ppc      <= start_pc;
      cur_hdr  <= sel_hdr;
      cur_addr <= sel_addr;
    end
  end
endmodule

// File: rtl/hd_checks.sv
module hd_checks #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lmi_valid,
  input logic            lmi_ready,
  input logic            ni_valid,
  input logic            ni_ready,
  input logic [1:0]      grant,
  input logic            ppcv,
  input logic [PC_W-1:0] ppc,
  input logic            fetch_last,
  input logic            sw_req,
  input logic            sw_ack
);
  p_one_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_lmi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lmi_valid && lmi_ready |=> !lmi_ready);

  p_ni_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ni_valid && ni_ready |=> !ni_ready);

  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |=> ppcv);

  p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ppcv && !fetch_last |=> ppcv && $stable(ppc));

  p_busy_nogrant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ppcv |-> grant == 2'b00);

  p_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ppcv && fetch_last |=> !ppcv);

  p_ack_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_ack |-> sw_req);

  p_ack_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_ack |=> !sw_ack);
endmodule

bind proto_dispatch hd_checks #(.PC_W(PC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q),
  .lmi_valid  (lmi_valid),
  .lmi_ready  (lmi_ready),
  .ni_valid   (ni_valid),
  .ni_ready   (ni_ready),
  .grant      (grant),
  .ppcv       (ppcv),
  .ppc        (ppc),
  .fetch_last (fetch_last),
  .sw_req     (sw_req),
  .sw_ack     (sw_ack)
);

// File: tb/test_proto_dispatch.sv
module test_proto_dispatch;
  localparam int TYPE_W = 4;
  localparam int HDR_W  = 16;
  localparam int ADDR_W = 32;
  localparam int PC_W   = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic lmi_valid, ni_valid, jt_we, fetch_last, sw_req;
  logic lmi_ready, ni_ready, ppcv, sw_ack;
  logic [HDR_W-1:0]  lmi_hdr, ni_hdr, sw_data;
  logic [ADDR_W-1:0] lmi_addr, ni_addr, ctx_addr;
  logic [TYPE_W-1:0] jt_idx;
  logic [PC_W-1:0]   jt_pc, ppc;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  proto_dispatch #(.TYPE_W(TYPE_W), .HDR_W(HDR_W), .ADDR_W(ADDR_W), .PC_W(PC_W))
  i_proto_dispatch (
    .clk(clk), .rst_n(rst_n),
    .lmi_valid(lmi_valid), .lmi_ready(lmi_ready), .lmi_hdr(lmi_hdr), .lmi_addr(lmi_addr),
    .ni_valid(ni_valid), .ni_ready(ni_ready), .ni_hdr(ni_hdr), .ni_addr(ni_addr),
    .jt_we(jt_we), .jt_idx(jt_idx), .jt_pc(jt_pc),
    .ppc(ppc), .ppcv(ppcv), .fetch_last(fetch_last),
    .sw_req(sw_req), .sw_ack(sw_ack), .sw_data(sw_data), .ctx_addr(ctx_addr)
  );

  function automatic logic [PC_W-1:0] tbl(input int k);
    return 32'h0040_0000 + 32'(k) * 32'h100;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  // drive at a negedge, return at the following negedge
  task automatic send(input bit use_lmi, input bit use_ni,
                      input logic [HDR_W-1:0] h0, input logic [ADDR_W-1:0] a0,
                      input logic [HDR_W-1:0] h1, input logic [ADDR_W-1:0] a1);
    lmi_valid = use_lmi; lmi_hdr = h0; lmi_addr = a0;
    ni_valid  = use_ni;  ni_hdr  = h1; ni_addr  = a1;
    @(posedge clk);
    @(negedge clk);
    lmi_valid = 1'b0;
    ni_valid  = 1'b0;
  endtask

  task automatic end_handler(input string tag);
    fetch_last = 1'b1;
    @(posedge clk);
    @(negedge clk);
    fetch_last = 1'b0;
    chk_eq({tag, " R5 run flag cleared"}, 64'(ppcv), 64'd0);
  endtask

  task automatic t_reset;
    chk_eq("R1 ppcv in reset", 64'(ppcv), 64'd0);
    chk_eq("R1 lmi_ready in reset", 64'(lmi_ready), 64'd1);
    chk_eq("R1 ni_ready in reset", 64'(ni_ready), 64'd1);
    chk_eq("R1 sw_ack in reset", 64'(sw_ack), 64'd0);
  endtask

  task automatic t_load_table;
    for (int k = 0; k < 16; k++) begin
      jt_we = 1'b1; jt_idx = TYPE_W'(k); jt_pc = tbl(k);
      @(posedge clk);
      @(negedge clk);
    end
    jt_we = 1'b0;
  endtask

  task automatic t_switch_blocks_idle;
    sw_req = 1'b1;
    @(negedge clk);
    chk_eq("R7 switch blocked with nothing dispatched", 64'(sw_ack), 64'd0);
    sw_req = 1'b0;
  endtask

  task automatic t_single_local;
    send(1'b1, 1'b0, 16'h7E03, 32'hDEAD_0040, '0, '0);
    chk_eq("R2 local ready low while held", 64'(lmi_ready), 64'd0);
    chk_eq("R3 not yet running", 64'(ppcv), 64'd0);
    @(negedge clk);
    chk_eq("R3 run flag set", 64'(ppcv), 64'd1);
    chk_eq("R3 start pc type 3", 64'(ppc), 64'(tbl(3)));
    chk_eq("R8 context address", 64'(ctx_addr), 64'h0000_0000_DEAD_0040);
    chk_eq("R2 local ready back after dispatch", 64'(lmi_ready), 64'd1);
    sw_req = 1'b1;
    #1;
    chk_eq("R7 switch completes", 64'(sw_ack), 64'd1);
    chk_eq("R7 switch header", 64'(sw_data), 64'h7E03);
    @(posedge clk);
    @(negedge clk);
    chk_eq("R7 second switch blocked", 64'(sw_ack), 64'd0);
    sw_req = 1'b0;
  endtask

  task automatic t_overlap_then_end;
    send(1'b0, 1'b1, '0, '0, 16'h1209, 32'h0000_BEE0);
    repeat (3) @(negedge clk);
    chk_eq("R4 still running old handler", 64'(ppcv), 64'd1);
    chk_eq("R4 pc held", 64'(ppc), 64'(tbl(3)));
    chk_eq("R4 network message still held", 64'(ni_ready), 64'd0);
    chk_eq("R8 context unchanged while busy", 64'(ctx_addr), 64'h0000_0000_DEAD_0040);
    end_handler("overlap");
    chk_eq("R5 no dispatch in clearing cycle", 64'(ppc), 64'(tbl(3)));
    @(negedge clk);
    chk_eq("R5 parked message dispatched", 64'(ppcv), 64'd1);
    chk_eq("R3 start pc type 9", 64'(ppc), 64'(tbl(9)));
    chk_eq("R8 context follows dispatch", 64'(ctx_addr), 64'h0000_0000_0000_BEE0);
  endtask

  task automatic t_idle_end_ignored;
    end_handler("first");
    end_handler("idle");
    @(negedge clk);
    chk_eq("R5 idle end pulse no effect on flag", 64'(ppcv), 64'd0);
    chk_eq("R5 idle end pulse no effect on pc", 64'(ppc), 64'(tbl(9)));
    sw_req = 1'b1;
    #1;
    chk_eq("R7 late switch returns pending header", 64'(sw_ack), 64'd1);
    chk_eq("R7 late switch header", 64'(sw_data), 64'h1209);
    @(posedge clk);
    @(negedge clk);
    sw_req = 1'b0;
  endtask

  task automatic t_tie(input string tag, input int win_t, input int lose_t,
                       input logic [HDR_W-1:0] lh, input logic [HDR_W-1:0] nh,
                       input bit lmi_wins);
    send(1'b1, 1'b1, lh, 32'hA100_0000 | 32'(lh), nh, 32'hA200_0000 | 32'(nh));
    chk_eq({tag, " R2 both held"}, 64'({lmi_ready, ni_ready}), 64'd0);
    @(negedge clk);
    chk_eq({tag, " R6 winner pc"}, 64'(ppc), 64'(tbl(win_t)));
    chk_eq({tag, " R10 loser still held"}, 64'(lmi_wins ? ni_ready : lmi_ready), 64'd0);
    chk_eq({tag, " R10 winner slot freed"}, 64'(lmi_wins ? lmi_ready : ni_ready), 64'd1);
    end_handler(tag);
    @(negedge clk);
    chk_eq({tag, " R6 loser follows"}, 64'(ppc), 64'(tbl(lose_t)));
    chk_eq({tag, " R8 loser address"}, 64'(ctx_addr),
           64'(lmi_wins ? (32'hA200_0000 | 32'(nh)) : (32'hA100_0000 | 32'(lh))));
    end_handler(tag);
  endtask

  task automatic t_rewrite;
    jt_we = 1'b1; jt_idx = 4'd5; jt_pc = 32'hCAFE_0000;
    @(posedge clk);
    @(negedge clk);
    jt_we = 1'b0;
    send(1'b1, 1'b0, 16'h6605, 32'h0000_5550, '0, '0);
    @(negedge clk);
    chk_eq("R9 rewritten entry used", 64'(ppc), 64'h0000_0000_CAFE_0000);
    end_handler("rewrite");
  endtask

  initial begin
    rst_n = 1'b0;
    lmi_valid = 1'b0; ni_valid = 1'b0; jt_we = 1'b0; fetch_last = 1'b0; sw_req = 1'b0;
    lmi_hdr = '0; ni_hdr = '0; lmi_addr = '0; ni_addr = '0; jt_idx = '0; jt_pc = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_load_table();
    t_switch_blocks_idle();
    t_single_local();
    t_overlap_then_end();
    t_idle_end_ignored();
    // last grant was the network port, so the local port wins this tie
    t_tie("tieA", 5, 12, 16'h2205, 16'h330C, 1'b1);
    // network granted last again; one local grant flips the pointer
    send(1'b1, 1'b0, 16'h0001, 32'h0000_0100, '0, '0);
    @(negedge clk);
    chk_eq("R3 start pc type 1", 64'(ppc), 64'(tbl(1)));
    end_handler("single");
    t_tie("tieB", 14, 2, 16'h4402, 16'h550E, 1'b0);
    t_rewrite();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule